// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the four active-low raster control signals for a display: horizontal sync, horizontal blank, vertical sync and vertical blank. A horizontal counter advances on every dot clock, and a vertical counter advances once per scan line. Each edge is placed by comparing a counter with a host-programmed register, so one block covers any mode whose timings fit in 12 bits. Both counter values come out on ports so that they can be read back.

Horizontal registers are written as the wanted count minus one. Vertical registers are written as plain line counts. All positions are measured from the sync falling edge. The block can lock to another video source: its external sync inputs pass through a two-stage synchroniser, and a falling edge on them loads the counters from programmable preload registers. Two lock modes exist. In the first, only the external vertical sync is used and it reloads both counters. In the second, each external sync reloads its own counter. The host writes all registers through a simple write-enable, address and data port.

Top module: `raster_timing_gen`

## Requirements
- R1: While rst_n is low at a clock edge, both counters become 0 and the registers take their default values. With the defaults, hsync_n, hblank_n, vsync_n and vblank_n are then all 0.
- R2: h_count steps by one on every clock. After the clock where it equals the horizontal total register (address 0), it goes to 0, so a line lasts total+1 clocks.
- R3: hsync_n is 0 when h_count is at most the horizontal sync register (address 1), so the pulse lasts that value plus one clock. Otherwise hsync_n is 1.
- R4: hblank_n is 1 only when h_count is above the blank-end register (address 2) and not above the blank-start register (address 3).
- R5: v_count steps by one on the same clock edge that takes h_count from its total to 0. After the line numbered vertical total (address 8) minus one, it goes to 0.
- R6: vsync_n is 0 when v_count is below the vertical sync register (address 9). vblank_n is 1 only when v_count is at least the blank-end register (address 10) and below the blank-start register (address 11).
- R7: A write with cfg_we high at a clock edge stores cfg_wdata into the register named by cfg_addr. The counters and outputs use the new value from the next clock edge on.
- R8: When mode register address 15 holds 0 or 3 (internal timing), the external sync inputs have no effect on the counters.
- R9: When the mode is 1 (external vertical only), a falling edge on ext_vsync_n loads h_count from the horizontal preload register (address 4) and v_count from the vertical preload register (address 12). Counting continues from the loaded values. In this mode ext_hsync_n is ignored.
- R10: When the mode is 2 (external both), a falling edge on ext_hsync_n loads only h_count from address 4, and a falling edge on ext_vsync_n loads only v_count from address 12.
- R11: A preload takes effect on the third rising clock edge after the external input falls. The preload takes priority over normal counting on that edge.
- R12: The default register values give a 1024x768 mode at four pixels per clock: horizontal 331/15/59/315, vertical 803/4/32/800, and both preloads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 12 | Register write data |
| ext_hsync_n | input | 1 | External horizontal sync, asynchronous, active low |
| ext_vsync_n | input | 1 | External vertical sync, asynchronous, active low |
| hsync_n | output | 1 | Horizontal sync, active low |
| hblank_n | output | 1 | Horizontal blank, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| vblank_n | output | 1 | Vertical blank, active low |
| h_count | output | 12 | Horizontal counter readback |
| v_count | output | 12 | Vertical counter readback |

## Verification
The four sync and blank outputs are decoded from the counters without a register, so they follow a counter change on the same edge. Register writes are seen from the edge after the write, and preloads land three edges after an external falling edge. The bench drives every input on the falling clock edge. It keeps a reference that advances on each rising edge and carries the same three-stage delay for the external inputs. All six outputs are compared on every falling edge. This covers the default mode, a small mode swept over several frames, and each lock mode.

// File: rtl/rtg_pkg.sv
// Shared constants for the raster timing generator: register
// addresses, timing modes and the default 1024x768 programming.
package rtg_pkg;

    localparam int unsigned RTG_W  = 12;
    localparam int unsigned ADDR_W = 4;

    // Register addresses
    localparam logic [ADDR_W-1:0] A_H_TOTAL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_H_SYNC   = 4'd1;
    localparam logic [ADDR_W-1:0] A_H_BEND   = 4'd2;
    localparam logic [ADDR_W-1:0] A_H_BSTART = 4'd3;
    localparam logic [ADDR_W-1:0] A_H_PRE    = 4'd4;
    localparam logic [ADDR_W-1:0] A_V_TOTAL  = 4'd8;
    localparam logic [ADDR_W-1:0] A_V_SYNC   = 4'd9;
    localparam logic [ADDR_W-1:0] A_V_BEND   = 4'd10;
    localparam logic [ADDR_W-1:0] A_V_BSTART = 4'd11;
    localparam logic [ADDR_W-1:0] A_V_PRE    = 4'd12;
    localparam logic [ADDR_W-1:0] A_MODE     = 4'd15;

    typedef enum logic [1:0] {
        MODE_INTERNAL = 2'd0,
        MODE_EXT_V    = 2'd1,
        MODE_EXT_HV   = 2'd2,
        MODE_RSVD     = 2'd3
    } tmode_e;

endpackage

// File: rtl/rtg_regs.sv
// Register file for the raster timing generator.
// Assumes a single write port and no readback; values are used
// directly by the counter axes. Reset loads a 1024x768 mode
// (four pixels per clock).
module rtg_regs
    import rtg_pkg::*;
#(
    parameter int unsigned W     = RTG_W,
    parameter int unsigned AW    = ADDR_W,
    parameter logic [W-1:0] D_H_TOTAL  = 331,
    parameter logic [W-1:0] D_H_SYNC   = 15,
    parameter logic [W-1:0] D_H_BEND   = 59,
    parameter logic [W-1:0] D_H_BSTART = 315,
    parameter logic [W-1:0] D_V_TOTAL  = 803,
    parameter logic [W-1:0] D_V_SYNC   = 4,
    parameter logic [W-1:0] D_V_BEND   = 32,
    parameter logic [W-1:0] D_V_BSTART = 800
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  h_total,
    output logic [W-1:0]  h_sync,
    output logic [W-1:0]  h_bend,
    output logic [W-1:0]  h_bstart,
    output logic [W-1:0]  h_pre,
    output logic [W-1:0]  v_total,
    output logic [W-1:0]  v_sync,
    output logic [W-1:0]  v_bend,
    output logic [W-1:0]  v_bstart,
    output logic [W-1:0]  v_pre,
    output tmode_e        mode
);

    // Reset to defaults, otherwise store a write into the addressed register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_total  <= D_H_TOTAL;
            h_sync   <= D_H_SYNC;
            h_bend   <= D_H_BEND;
            h_bstart <= D_H_BSTART;
            h_pre    <= '0;
            v_total  <= D_V_TOTAL;
            v_sync   <= D_V_SYNC;
            v_bend   <= D_V_BEND;
            v_bstart <= D_V_BSTART;
            v_pre    <= '0;
            mode     <= MODE_INTERNAL;
        end else if (we) begin
            case (addr)
                A_H_TOTAL:  h_total  <= wdata;
                A_H_SYNC:   h_sync   <= wdata;
                A_H_BEND:   h_bend   <= wdata;
                A_H_BSTART: h_bstart <= wdata;
                A_H_PRE:    h_pre    <= wdata;
                A_V_TOTAL:  v_total  <= wdata;
                A_V_SYNC:   v_sync   <= wdata;
                A_V_BEND:   v_bend   <= wdata;
                A_V_BSTART: v_bstart <= wdata;
                A_V_PRE:    v_pre    <= wdata;
                A_MODE:     mode     <= tmode_e'(wdata[1:0]);
                default: ;
            endcase
        end
    end

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mode)); // R7

endmodule

// File: rtl/rtg_sync_edge.sv
// Synchroniser and falling-edge detector for one external sync input.
// Assumes an asynchronous, idle-high input. Pulses fall for one clock
// STAGES+1 edges after the input goes low (detection uses the last
// stage and one extra history flop).
module rtg_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_n,
    output logic fall
);

    logic [STAGES:0] chain;

    // Shift the input through the synchroniser stages and a history flop
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-1:0], din_n};
    end

    // Falling edge: history high, newest synchronised sample low
    always_comb fall = chain[STAGES] & ~chain[STAGES-1];

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall); // R11

endmodule

// File: rtl/rtg_axis.sv
// One timing axis: a counter with preload and the sync/blank decode.
// HORIZ=1: registers hold count-minus-one; wraps after cnt==total,
//          sync low for cnt<=sync, blank off for bend<cnt<=bstart.
// HORIZ=0: registers hold plain counts; wraps after cnt==total-1,
//          sync low for cnt<sync, blank off for bend<=cnt<bstart.
// Assumes legal programming sync < bend < bstart < total.
module rtg_axis #(
    parameter int unsigned W     = 12,
    parameter bit          HORIZ = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         advance,
    input  logic         preload,
    input  logic [W-1:0] preload_val,
    input  logic [W-1:0] total,
    input  logic [W-1:0] sync_len,
    input  logic [W-1:0] blank_end,
    input  logic [W-1:0] blank_start,
    output logic [W-1:0] cnt,
    output logic         wrap,
    output logic         sync_n,
    output logic         blank_n
);

    localparam logic [W-1:0] ONE = W'(1);

    logic at_end;

    generate
        if (HORIZ) begin : g_minus_one
            // Decode against count-minus-one registers
            always_comb begin
                at_end  = (cnt >= total);
                sync_n  = !(cnt <= sync_len);
                blank_n = (cnt > blank_end) && (cnt <= blank_start);
            end
        end else begin : g_plain
            // Decode against plain-count registers
            always_comb begin
                at_end  = (cnt >= (total - ONE));
                sync_n  = !(cnt < sync_len);
                blank_n = (cnt >= blank_end) && (cnt < blank_start);
            end
        end
    endgenerate

    // Wrap request when advancing from the last position
    always_comb wrap = advance && at_end;

    // Counter: preload first, then advance with wrap
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (preload) cnt <= preload_val;
        else if (advance) cnt <= at_end ? '0 : cnt + ONE;
    end

    AST_PRELOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        preload |=> cnt == $past(preload_val)); // R11

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !preload && !advance |=> $stable(cnt)); // R5

endmodule

// File: rtl/raster_timing_gen.sv
// Programmable raster timing generator (top).
// Horizontal axis steps every dot clock; vertical axis steps on the
// horizontal wrap. External syncs can preload the counters.
// Assumes external sync pulses are at least one clock wide and
// shorter than the programmed horizontal sync.
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int unsigned W      = RTG_W,
    parameter int unsigned AW     = ADDR_W,
    parameter int unsigned STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [W-1:0]  cfg_wdata,
    input  logic          ext_hsync_n,
    input  logic          ext_vsync_n,
    output logic          hsync_n,
    output logic          hblank_n,
    output logic          vsync_n,
    output logic          vblank_n,
    output logic [W-1:0]  h_count,
    output logic [W-1:0]  v_count
);

    logic [W-1:0] h_total, h_sync, h_bend, h_bstart, h_pre;
    logic [W-1:0] v_total, v_sync, v_bend, v_bstart, v_pre;
    tmode_e       mode;
    logic         h_fall, v_fall, h_load, v_load, h_wrap, v_wrap;

    rtg_regs #(.W(W), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .h_total(h_total), .h_sync(h_sync), .h_bend(h_bend), .h_bstart(h_bstart),
        .h_pre(h_pre), .v_total(v_total), .v_sync(v_sync), .v_bend(v_bend),
        .v_bstart(v_bstart), .v_pre(v_pre), .mode(mode)
    );

    rtg_sync_edge #(.STAGES(STAGES)) u_hedge (
        .clk(clk), .rst_n(rst_n), .din_n(ext_hsync_n), .fall(h_fall)
    );

    rtg_sync_edge #(.STAGES(STAGES)) u_vedge (
        .clk(clk), .rst_n(rst_n), .din_n(ext_vsync_n), .fall(v_fall)
    );

    // Select which external edge loads which counter for the current mode
    always_comb begin
        h_load = 1'b0;
        v_load = 1'b0;
        case (mode)
            MODE_EXT_V: begin
                h_load = v_fall;
                v_load = v_fall;
            end
            MODE_EXT_HV: begin
                h_load = h_fall;
                v_load = v_fall;
            end
            default: ;
        endcase
    end

    rtg_axis #(.W(W), .HORIZ(1'b1)) u_haxis (
        .clk(clk), .rst_n(rst_n), .advance(1'b1), .preload(h_load),
        .preload_val(h_pre), .total(h_total), .sync_len(h_sync),
        .blank_end(h_bend), .blank_start(h_bstart),
        .cnt(h_count), .wrap(h_wrap), .sync_n(hsync_n), .blank_n(hblank_n)
    );

    rtg_axis #(.W(W), .HORIZ(1'b0)) u_vaxis (
        .clk(clk), .rst_n(rst_n), .advance(h_wrap), .preload(v_load),
        .preload_val(v_pre), .total(v_total), .sync_len(v_sync),
        .blank_end(v_bend), .blank_start(v_bstart),
        .cnt(v_count), .wrap(v_wrap), .sync_n(vsync_n), .blank_n(vblank_n)
    );

    AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !h_wrap && !v_load |=> $stable(v_count)); // R5

    AST_INTERNAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_INTERNAL) && (h_count < h_total)
        |=> h_count == $past(h_count) + W'(1)); // R8

    AST_HSYNC_AT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        h_wrap && !h_load |=> !hsync_n); // R3

    AST_VSYNC_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        h_wrap && v_wrap && !v_load && !cfg_we && (v_sync != '0) |=> !vsync_n); // R6

endmodule

// File: tb/sim_raster_timing_gen.sv
module sim_raster_timing_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [11:0] cfg_wdata = '0;
    logic        ext_hsync_n = 1'b1;
    logic        ext_vsync_n = 1'b1;
    logic        hsync_n, hblank_n, vsync_n, vblank_n;
    logic [11:0] h_count, v_count;

    int errors = 0;
    int checks = 0;
    bit chk_en = 1'b0;
    bit done = 1'b0;
    string phase = "R12";

    always #2.5 clk = ~clk;

    raster_timing_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ext_hsync_n(ext_hsync_n), .ext_vsync_n(ext_vsync_n),
        .hsync_n(hsync_n), .hblank_n(hblank_n), .vsync_n(vsync_n), .vblank_n(vblank_n),
        .h_count(h_count), .v_count(v_count)
    );

    // Reference model built from the requirements
    logic [11:0] mh, mv;
    logic [11:0] r_ht, r_hs, r_hbe, r_hbs, r_hp, r_vt, r_vs, r_vbe, r_vbs, r_vp;
    logic [1:0]  r_mode;
    logic [2:0]  hp_pipe, vp_pipe;   // two sync stages plus history (R11)

    always @(posedge clk) begin
        if (!rst_n) begin
            mh <= 0; mv <= 0;
            r_ht <= 331; r_hs <= 15; r_hbe <= 59; r_hbs <= 315; r_hp <= 0;
            r_vt <= 803; r_vs <= 4;  r_vbe <= 32; r_vbs <= 800; r_vp <= 0;
            r_mode <= 0; hp_pipe <= '1; vp_pipe <= '1;
        end else begin
            logic [11:0] nh, nv;
            logic hf, vf, hw;
            hf = hp_pipe[2] & ~hp_pipe[1];
            vf = vp_pipe[2] & ~vp_pipe[1];
            hw = (mh >= r_ht);
            nh = hw ? 12'd0 : mh + 12'd1;
            nv = hw ? ((mv >= r_vt - 12'd1) ? 12'd0 : mv + 12'd1) : mv;
            if (r_mode == 2'd1 && vf) begin nh = r_hp; nv = r_vp; end
            if (r_mode == 2'd2) begin
                if (hf) nh = r_hp;
                if (vf) nv = r_vp;
            end
            mh <= nh; mv <= nv;
            hp_pipe <= {hp_pipe[1:0], ext_hsync_n};
            vp_pipe <= {vp_pipe[1:0], ext_vsync_n};
            if (cfg_we) begin
                case (cfg_addr)
                    4'd0: r_ht <= cfg_wdata;  4'd1: r_hs <= cfg_wdata;
                    4'd2: r_hbe <= cfg_wdata; 4'd3: r_hbs <= cfg_wdata;
                    4'd4: r_hp <= cfg_wdata;  4'd8: r_vt <= cfg_wdata;
                    4'd9: r_vs <= cfg_wdata;  4'd10: r_vbe <= cfg_wdata;
                    4'd11: r_vbs <= cfg_wdata; 4'd12: r_vp <= cfg_wdata;
                    4'd15: r_mode <= cfg_wdata[1:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s (phase %s): actual=%0d expected=%0d", req, phase, act, exp);
        end
    endtask

    // Compare every output away from the active edge
    always @(negedge clk) begin
        if (chk_en) begin
            check("R2 h_count", h_count, mh);
            check("R5 v_count", v_count, mv);
            check("R3 hsync_n", hsync_n, !(mh <= r_hs));
            check("R4 hblank_n", hblank_n, (mh > r_hbe) && (mh <= r_hbs));
            check("R6 vsync_n", vsync_n, !(mv < r_vs));
            check("R6 vblank_n", vblank_n, (mv >= r_vbe) && (mv < r_vbs));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [11:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_h();
        @(negedge clk); ext_hsync_n = 1'b0;
        @(negedge clk); ext_hsync_n = 1'b1;
    endtask

    task automatic pulse_v();
        @(negedge clk); ext_vsync_n = 1'b0;
        @(negedge clk); ext_vsync_n = 1'b1;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 h_count", h_count, 0);
        check("R1 v_count", v_count, 0);
        check("R1 hsync_n", hsync_n, 0);
        check("R1 hblank_n", hblank_n, 0);
        check("R1 vsync_n", vsync_n, 0);
        check("R1 vblank_n", vblank_n, 0);
        rst_n = 1'b1;
        chk_en = 1'b1;
        // R12: default mode over two full lines
        phase = "R12";
        run(700);
        // R7: program a small mode, sweep several frames
        phase = "R7";
        wr(4'd0, 12'd9);  wr(4'd1, 12'd1); wr(4'd2, 12'd3); wr(4'd3, 12'd7);
        wr(4'd8, 12'd5);  wr(4'd9, 12'd1); wr(4'd10, 12'd2); wr(4'd11, 12'd4);
        run(160);
        // R8: internal mode ignores external syncs
        phase = "R8";
        wr(4'd4, 12'd4); wr(4'd12, 12'd3);
        pulse_h(); run(5); pulse_v(); run(60);
        // R9: external vertical only
        phase = "R9";
        wr(4'd15, 12'd1);
        run(4); pulse_v(); run(40); pulse_h(); run(60);
        // R10 and R11: external both
        phase = "R10";
        wr(4'd4, 12'd6); wr(4'd12, 12'd1); wr(4'd15, 12'd2);
        run(3); pulse_h(); run(30); pulse_v(); run(60);
        // R8: mode 3 behaves as internal
        phase = "R8";
        wr(4'd15, 12'd3);
        pulse_v(); run(5); pulse_h(); run(40);
        chk_en = 1'b0;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule